// File: doc/BRIEF.md
# Cache Invalidation Probe Queue

This block sits on the incoming coherence path of one processor's cache. Invalidate probes from the interconnect go into a FIFO and are acknowledged in the same cycle they are accepted. The matching cache line is killed later. Queued invalidates are written into a small direct-mapped tag array, one per cycle, but only in cycles when no reply fill and no core read is using the array.

Data replies to the processor's own reads do not pass through the FIFO. A reply is written into the array at once and forwarded to the core on the next cycle, ahead of any invalidates still waiting. Until an invalidate is applied, core reads that hit its line return the old cached data. The more probes there are ahead of an invalidate, the longer that stale window lasts.

A memory-barrier request from the core starts a drain. While the drain runs, queued invalidates take the array slot ahead of core reads. Barrier-done pulses once the FIFO is empty and its last invalidate has been written to the array.

Top module: `inval_probe_queue`

## Requirements
- R1: After reset the FIFO is empty, every line is invalid, `prb_ready` and `rd_ready` are high, and `prb_ack`, `bar_done`, `rd_rsp_valid` and `fill_valid` are low. Any read then misses.
- R2: A probe is acknowledged (`prb_ack` high) in the same cycle it is accepted, before its line is invalidated.
- R3: A queued invalidate is applied only in a cycle with no reply fill and no accepted core read. Until it is applied, reads of its line hit with the old data.
- R4: An address is {tag, index}, with the index in the low `IDXW` bits. A read accepted at an edge gives `rd_rsp_valid` for one cycle after that edge. `rd_hit` is high when the line is valid and its tag equals the address tag, and `rd_data` is the stored word.
- R5: A reply writes its line (valid, tag, data) at the edge where it is presented, whatever is queued. `fill_valid` and `fill_data` echo the reply one cycle later. `rd_ready` is low in a reply cycle.
- R6: An invalidate clears the line's valid bit only if the stored tag matches the probe tag. Otherwise the line keeps hitting.
- R7: The FIFO holds `DEPTH` probes. When it is full, `prb_ready` is low, and a presented probe is neither acknowledged nor queued.
- R8: While a barrier is draining and the FIFO is not empty, `rd_ready` is low and invalidates are applied one per cycle in arrival order.
- R9: `bar_done` is high for exactly one cycle. The number of edges from the edge that samples `bar_req` to the cycle where `bar_done` is seen equals the FIFO occupancy at that edge, so an empty FIFO gives `bar_done` right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prb_valid | input | 1 | Invalidate probe present |
| prb_ready | output | 1 | FIFO has room |
| prb_addr | input | AW | Line address of the probe |
| prb_ack | output | 1 | Probe acknowledged to the sender |
| rpl_valid | input | 1 | Data reply present |
| rpl_addr | input | AW | Line address of the reply |
| rpl_data | input | DW | Reply data |
| fill_valid | output | 1 | Reply forwarded to the core |
| fill_data | output | DW | Forwarded reply data |
| rd_req | input | 1 | Core read request |
| rd_ready | output | 1 | Core read accepted this cycle |
| rd_addr | input | AW | Core read address |
| rd_rsp_valid | output | 1 | Read result valid |
| rd_hit | output | 1 | Read hit |
| rd_data | output | DW | Read data |
| bar_req | input | 1 | Barrier request pulse |
| bar_done | output | 1 | Barrier complete pulse |

## Verification
The bench keeps core reads busy every cycle, so queued invalidates stay pending, and checks that the old data is still returned. A design that invalidated at enqueue time would miss early. A design that let invalidates steal the slot would miss partway through. It measures barrier latency against the exact FIFO occupancy, including an empty FIFO and a full one. An off-by-one done pulse, a fifth probe slipping into a full FIFO, or reads allowed during the drain would each change the count. It places a reply for a line between that line's queued invalidate and the barrier: a reply that waited behind the FIFO would not hit early, and an invalidate that ignored the tag would kill a mismatched line.

// File: rtl/inval_probe_queue.sv
module inval_probe_queue #(
  parameter int IDXW  = 2,
  parameter int TAGW  = 2,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = IDXW + TAGW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prb_valid,
  output logic          prb_ready,
  input  logic [AW-1:0] prb_addr,
  output logic          prb_ack,
  input  logic          rpl_valid,
  input  logic [AW-1:0] rpl_addr,
  input  logic [DW-1:0] rpl_data,
  output logic          fill_valid,
  output logic [DW-1:0] fill_data,
  input  logic          rd_req,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_rsp_valid,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  input  logic          bar_req,
  output logic          bar_done
);
  localparam int LINES = 1 << IDXW;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [AW-1:0]   q_mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt;
  logic            bar_active;

  logic [LINES-1:0] vld;
  logic [TAGW-1:0]  tag_mem [LINES];
  logic [DW-1:0]    dat_mem [LINES];

  logic            accept, pop, draining, rd_go;
  logic [AW-1:0]   head;
  logic [IDXW-1:0] h_idx, f_idx, r_idx;
  logic [TAGW-1:0] h_tag, f_tag, r_tag;

  assign prb_ready = cnt != CW'(DEPTH);
  assign accept    = prb_valid && prb_ready;
  assign prb_ack   = accept;
  assign draining  = bar_active && (cnt != '0);
  assign rd_ready  = !rpl_valid && !draining;
  assign rd_go     = rd_req && rd_ready;
  assign pop       = (cnt != '0) && !rpl_valid && !rd_go;
  assign bar_done  = bar_active && (cnt == '0);

  assign head  = q_mem[rd_ptr];
  assign h_idx = head[IDXW-1:0];
  assign h_tag = head[AW-1:IDXW];
  assign f_idx = rpl_addr[IDXW-1:0];
  assign f_tag = rpl_addr[AW-1:IDXW];
  assign r_idx = rd_addr[IDXW-1:0];
  assign r_tag = rd_addr[AW-1:IDXW];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (pop)    rd_ptr <= nxt(rd_ptr);
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) q_mem[wr_ptr] <= prb_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bar_active <= 1'b0;
    else if (bar_done) bar_active <= 1'b0;
    else if (bar_req) bar_active <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (rpl_valid) vld[f_idx] <= 1'b1;
    else if (pop && vld[h_idx] && tag_mem[h_idx] == h_tag) vld[h_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rpl_valid) begin
      tag_mem[f_idx] <= f_tag;
      dat_mem[f_idx] <= rpl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_hit       <= 1'b0;
      rd_data      <= '0;
      fill_valid   <= 1'b0;
      fill_data    <= '0;
    end else begin
      rd_rsp_valid <= rd_go;
      if (rd_go) begin
        rd_hit  <= vld[r_idx] && (tag_mem[r_idx] == r_tag);
        rd_data <= dat_mem[r_idx];
      end
      fill_valid <= rpl_valid;
      if (rpl_valid) fill_data <= rpl_data;
    end
  end
endmodule

// File: rtl/inval_probe_queue_chk.sv
module inval_probe_queue_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          rd_req,
  input logic          rd_ready,
  input logic          rd_rsp_valid,
  input logic          rpl_valid,
  input logic          fill_valid,
  input logic          prb_ack,
  input logic          prb_ready,
  input logic          bar_done
);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) == 32'($past(cnt))) || (32'(cnt) == 32'($past(cnt)) + 1) ||
    (32'(cnt) + 1 == 32'($past(cnt))));

  p_full_grows_no_more_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !prb_ready |=> 32'(cnt) <= 32'($past(cnt)));

  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !bar_done);

  p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> $past(rd_req && rd_ready));

  p_fill_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(rpl_valid));

  p_ack_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prb_ack |=> 32'(cnt) >= 1);
endmodule

bind inval_probe_queue inval_probe_queue_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .rd_req(rd_req), .rd_ready(rd_ready),
  .rd_rsp_valid(rd_rsp_valid), .rpl_valid(rpl_valid), .fill_valid(fill_valid),
  .prb_ack(prb_ack), .prb_ready(prb_ready), .bar_done(bar_done)
);

// File: tb/inval_probe_queue_tb_top.sv
`timescale 1ns/1ps
module inval_probe_queue_tb_top;
  localparam int IDXW = 2, TAGW = 2, DW = 8, DEPTH = 4, AW = IDXW + TAGW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prb_valid = 0, rpl_valid = 0, rd_req = 0, bar_req = 0;
  logic [AW-1:0] prb_addr = '0, rpl_addr = '0, rd_addr = '0;
  logic [DW-1:0] rpl_data = '0;
  logic prb_ready, prb_ack, fill_valid, rd_ready, rd_rsp_valid, rd_hit, bar_done;
  logic [DW-1:0] fill_data, rd_data;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  inval_probe_queue #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr), .prb_ack(prb_ack),
    .rpl_valid(rpl_valid), .rpl_addr(rpl_addr), .rpl_data(rpl_data),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_hit(rd_hit), .rd_data(rd_data),
    .bar_req(bar_req), .bar_done(bar_done));

  task automatic ck(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i);
    return AW'((t << IDXW) | i);
  endfunction

  function automatic logic [DW-1:0] pat(input int t, input int i);
    return DW'(((t << IDXW) | i) * 7 + 3);
  endfunction

  task automatic fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
    rpl_valid = 1; rpl_addr = a; rpl_data = d;
    #1 ck("R5", "rd_ready low during reply", rd_ready, 0);
    cyc();
    rpl_valid = 0;
    ck("R5", "fill_valid", fill_valid, 1);
    ck("R5", "fill_data", fill_data, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic ehit, input logic [DW-1:0] ed, input string req);
    rd_req = 1; rd_addr = a;
    cyc();
    rd_req = 0;
    ck(req, "rd_rsp_valid", rd_rsp_valid, 1);
    ck(req, $sformatf("rd_hit addr %0h", a), rd_hit, ehit);
    if (ehit) ck(req, $sformatf("rd_data addr %0h", a), rd_data, ed);
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic eack);
    prb_valid = 1; prb_addr = a;
    #1 ck("R2_R7", "prb_ack", prb_ack, eack);
    ck("R7", "prb_ready", prb_ready, eack);
    cyc();
    prb_valid = 0;
  endtask

  task automatic barrier(input int elat);
    int n = 0;
    bar_req = 1;
    cyc();
    bar_req = 0;
    #1;
    while (!bar_done && n < 40) begin
      if (n < elat) ck("R8", "rd_ready low while draining", rd_ready, 0);
      cyc(); #1; n++;
    end
    ck("R9", "barrier latency", n, elat);
    cyc(); #1;
    ck("R9", "bar_done single cycle", bar_done, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    #1;
    ck("R1", "prb_ready", prb_ready, 1);
    ck("R1", "rd_ready", rd_ready, 1);
    ck("R1", "bar_done", bar_done, 0);
    ck("R1", "prb_ack", prb_ack, 0);
    ck("R1", "rd_rsp_valid", rd_rsp_valid, 0);
    ck("R1", "fill_valid", fill_valid, 0);
    for (int a = 0; a < (1 << AW); a++) rd(AW'(a), 0, '0, "R1");

    // R4 R5: sweep every tag over every line
    for (int t = 0; t < (1 << TAGW); t++) begin
      for (int i = 0; i < (1 << IDXW); i++) fill(mk(t, i), pat(t, i));
      for (int a = 0; a < (1 << AW); a++)
        rd(AW'(a), (a >> IDXW) == t, pat(t, a & ((1 << IDXW) - 1)), "R4");
    end

    // R2 R3: idle cycle applies an acknowledged invalidate
    probe(mk(3, 1), 1);
    cyc();
    rd(mk(3, 1), 0, '0, "R3");
    rd(mk(3, 0), 1, pat(3, 0), "R3");

    // R3: stale hits while reads hold the port
    rd_req = 1; rd_addr = mk(3, 2);
    probe(mk(3, 2), 1);
    for (int k = 0; k < 5; k++) begin
      cyc();
      ck("R3", "stale hit", rd_hit, 1);
      ck("R3", "stale data", rd_data, pat(3, 2));
    end
    barrier(1);
    rd_req = 0;
    rd(mk(3, 2), 0, '0, "R8");

    // R6: tag mismatch keeps the line
    rd_req = 1; rd_addr = mk(3, 3);
    probe(mk(0, 3), 1);
    barrier(1);
    rd_req = 0;
    rd(mk(3, 3), 1, pat(3, 3), "R6");

    // R7: full FIFO refuses a fifth probe
    rd_req = 1; rd_addr = mk(3, 0);
    for (int i = 0; i < DEPTH; i++) probe(mk(3, i), 1);
    probe(mk(2, 0), 0);
    barrier(DEPTH);
    rd_req = 0;
    #1 ck("R7", "prb_ready after drain", prb_ready, 1);
    for (int i = 0; i < (1 << IDXW); i++) rd(mk(3, i), 0, '0, "R7");

    // R5 R8: reply bypasses a queued invalidate; FIFO order kept
    for (int i = 0; i < (1 << IDXW); i++) fill(mk(1, i), pat(1, i));
    rd_req = 1; rd_addr = mk(1, 0);
    probe(mk(1, 0), 1);
    probe(mk(2, 1), 1);
    probe(mk(1, 1), 1);
    fill(mk(1, 0), 8'hA5);
    rd_req = 1; rd_addr = mk(1, 0);
    cyc();
    ck("R5", "bypass hit", rd_hit, 1);
    ck("R5", "bypass data", rd_data, 8'hA5);
    barrier(3);
    rd_req = 0;
    rd(mk(1, 0), 0, '0, "R8");
    rd(mk(1, 1), 0, '0, "R8");
    rd(mk(1, 2), 1, pat(1, 2), "R8");

    // R9: empty FIFO
    barrier(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule